// File: doc/BRIEF.md
# HDLC receive deframer

This block turns a serial line into whole bytes. It takes one bit per cycle in which `bit_en` is high. It locks onto flag delimiters, drops the zeros that a transmitter inserts after five ones, and puts the recovered bytes out on a byte-wide stream. The stream marks the first byte and the last byte of each frame. Each frame is checked against its trailing check sequence, which is 16 or 32 bits wide. The result is reported in the same cycle as the last byte: good check, bad check, abort, or a length that is not a whole number of octets.

A configuration input decides what happens to the received check-sequence bytes. They either go out with the data or are removed, in which case the end-of-frame marker sits on the last payload byte. Some frames are too short to carry a check sequence and at least two further bytes; these frames and empty flag-to-flag gaps make no output at all. The configuration inputs are meant to be static while a frame is being received.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: The pattern 01111110 opens and closes frames. Bits that arrive before the first flag, or after an abort and before the next flag, produce no output.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed and is not part of the data.
- R3: Bytes are assembled least-significant bit first: the first data bit after a byte boundary becomes `out_data[0]`.
- R4: With `cfg_crc32`=0 the check uses the 16-bit reflected polynomial 0x8408, preset to all ones. A frame closes with `st_fcs_ok` when the register ends at 0xF0B8, and with `st_fcs_bad` otherwise.
- R5: With `cfg_crc32`=1 the check uses the 32-bit reflected polynomial 0xEDB88320, preset to all ones. A frame closes with `st_fcs_ok` when the register ends at 0xDEBB20E3, and with `st_fcs_bad` otherwise.
- R6: With `cfg_keep_fcs`=0 the 2 or 4 check-sequence bytes are not output, and `out_eof` sits on the last payload byte.
- R7: With `cfg_keep_fcs`=1 every received byte is output, check-sequence bytes included, and `out_eof` sits on the last check-sequence byte.
- R8: Seven consecutive 1s abort the frame. If the frame has already put out bytes, one more beat follows with `out_eof` and `st_abort`, and that beat carries the oldest byte still held. Otherwise the frame makes no output.
- R9: A frame of fewer than (check bytes + 2) bytes makes no output, and neither do adjacent flags.
- R10: If the number of data bits between flags is not a multiple of eight, the closing beat carries both `st_misalign` and `st_fcs_bad`.
- R11: `out_sof` marks the first beat of a frame and `out_eof` marks its last beat. On the `out_eof` beat exactly one of `st_fcs_ok`, `st_fcs_bad` and `st_abort` is high. All status outputs are low on every other cycle.
- R12: While reset is held, and right after it, `out_valid`, `out_sof`, `out_eof` and all status outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Qualifies `bit_in` as one received line bit |
| bit_in | input | 1 | Serial receive data |
| cfg_crc32 | input | 1 | 1 selects the 32-bit check, 0 selects the 16-bit check |
| cfg_keep_fcs | input | 1 | 1 forwards the check-sequence bytes, 0 strips them |
| out_valid | output | 1 | A byte is present on `out_data` |
| out_data | output | 8 | Received byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame; status is valid with it |
| st_fcs_ok | output | 1 | Check sequence correct |
| st_fcs_bad | output | 1 | Check sequence wrong or length misaligned |
| st_abort | output | 1 | Frame ended by an abort |
| st_misalign | output | 1 | Bit count not a multiple of eight |

## Verification
Some properties are checked by assertions on every cycle:
- start and end markers appear only with a valid byte;
- on the closing beat exactly one outcome is reported, and no status shows outside that beat;
- a misalignment always comes with a bad check;
- the byte hold queue never goes past the depth that the selected check width allows;
- the serial flush in forward mode is never overlapped by a new byte, flag or abort;
- an abort pulse fires only once in a run of ones.

Other behaviour can only be shown by the bench's frames. That covers the exact bytes after destuffing, where the markers fall under each check width and strip setting, the check residues themselves, discarding of short frames, and the content of the extra beat on an abort.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int OCTET      = 8;
  localparam int FLAG_RUN   = 6;
  localparam int SR_W       = OCTET + FLAG_RUN;
  localparam int PH_W       = $clog2(OCTET);
  localparam int FCS16_B    = 2;
  localparam int FCS32_B    = 4;
  localparam int HOLD_DEPTH = FCS32_B + 1;
  localparam int OCC_W      = $clog2(HOLD_DEPTH + 1);

  localparam logic [15:0] POLY16 = 16'h8408;
  localparam logic [15:0] GOOD16 = 16'hF0B8;
  localparam logic [31:0] POLY32 = 32'hEDB88320;
  localparam logic [31:0] GOOD32 = 32'hDEBB20E3;

  typedef struct packed {
    logic ok;
    logic bad;
    logic abort;
    logic misalign;
  } rx_stat_t;
endpackage

// File: rtl/hdlc_rx_bitproc.sv
module hdlc_rx_bitproc
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic dbit_vld,
  output logic dbit,
  output logic flag_ev,
  output logic abort_ev
);
  logic [2:0] ones_q, ones_d;

  always_comb begin
    ones_d   = ones_q;
    dbit_vld = 1'b0;
    flag_ev  = 1'b0;
    abort_ev = 1'b0;
    dbit     = bit_in;
    if (bit_en) begin
      if (bit_in) begin
        ones_d   = (ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1;
        dbit_vld = (ones_q < 3'(FLAG_RUN - 1));
        abort_ev = (ones_q == 3'(FLAG_RUN));
      end else begin
        ones_d   = 3'd0;
        flag_ev  = (ones_q == 3'(FLAG_RUN));
        dbit_vld = (ones_q != 3'(FLAG_RUN - 1)) && (ones_q != 3'(FLAG_RUN));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= 3'd0;
    else if (bit_en) ones_q <= ones_d;
  end

  // R8
  abort_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> !abort_ev);
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
  parameter int         W    = 16,
  parameter logic [W-1:0] POLY = 16'h8408,
  parameter logic [W-1:0] GOOD = 16'hF0B8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic din,
  output logic good
);
  logic [W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr) crc_d = '1;
    else if (en) crc_d = (crc_q >> 1) ^ ((crc_q[0] ^ din) ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else if (clr || en) crc_q <= crc_d;
  end

  assign good = (crc_q == GOOD);
endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
  import hdlc_rx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_crc32,
  input  logic            cfg_keep_fcs,
  input  logic            dbit_vld,
  input  logic            dbit,
  input  logic            flag_ev,
  input  logic            abort_ev,
  input  logic            crc_good,
  output logic            crc_clr,
  output logic            crc_en,
  output logic            crc_din,
  output logic            o_valid,
  output logic [OCTET-1:0] o_data,
  output logic            o_sof,
  output logic            o_eof,
  output rx_stat_t        o_stat
);
  logic [SR_W-1:0]  sr_q, sr_d;
  logic [2:0]       pre_q, pre_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             inf_q, inf_d, sent_q, sent_d, fl_q, fl_d;
  logic [OCC_W-1:0] occ_q, occ_d, lim, idx;
  logic [OCTET-1:0] q_q [HOLD_DEPTH];
  logic [OCTET-1:0] q_d [HOLD_DEPTH];
  rx_stat_t         hold_q, hold_d, st_d, end_st, ab_st;
  logic             ov_d, sof_d, eof_d, pop, confirm, byte_done;
  logic [OCTET-1:0] od_d, new_byte;

  assign lim = cfg_crc32 ? OCC_W'(HOLD_DEPTH) : OCC_W'(FCS16_B + 1);

  // bit alignment: bits are confirmed as data FLAG_RUN emissions late
  always_comb begin
    sr_d      = sr_q;
    pre_d     = pre_q;
    ph_d      = ph_q;
    confirm   = 1'b0;
    byte_done = 1'b0;
    if (flag_ev) begin
      pre_d = 3'd0;
      ph_d  = '0;
    end else if (dbit_vld) begin
      sr_d = {dbit, sr_q[SR_W-1:1]};
      if (pre_q == 3'(FLAG_RUN)) begin
        confirm   = 1'b1;
        byte_done = (ph_q == PH_W'(OCTET - 1));
        ph_d      = ph_q + 1'b1;
      end else begin
        pre_d = pre_q + 3'd1;
      end
    end
  end

  assign new_byte = sr_d[OCTET-1:0];
  assign crc_clr  = flag_ev;
  assign crc_en   = confirm;
  assign crc_din  = sr_d[OCTET-1];

  always_comb begin
    end_st          = '0;
    end_st.misalign = (ph_q != '0);
    end_st.ok       = crc_good && (ph_q == '0);
    end_st.bad      = !end_st.ok;
    ab_st           = '0;
    ab_st.abort     = 1'b1;
  end

  // frame control and byte hold queue
  always_comb begin
    q_d    = q_q;
    occ_d  = occ_q;
    fl_d   = fl_q;
    hold_d = hold_q;
    sent_d = sent_q;
    inf_d  = inf_q;
    ov_d   = 1'b0;
    sof_d  = 1'b0;
    eof_d  = 1'b0;
    st_d   = '0;
    od_d   = o_data;
    pop    = 1'b0;
    idx    = (occ_q == lim) ? occ_q - 1'b1 : occ_q;
    if (fl_q) begin
      pop   = 1'b1;
      occ_d = occ_q - 1'b1;
      if (occ_q == OCC_W'(1)) begin
        eof_d = 1'b1;
        st_d  = hold_q;
        fl_d  = 1'b0;
      end
    end else if (flag_ev) begin
      inf_d  = 1'b1;
      sent_d = 1'b0;
      if (inf_q && sent_q) begin
        if (cfg_keep_fcs) begin
          fl_d   = 1'b1;
          hold_d = end_st;
        end else begin
          pop   = 1'b1;
          eof_d = 1'b1;
          st_d  = end_st;
          occ_d = '0;
        end
      end else begin
        occ_d = '0;
      end
    end else if (abort_ev) begin
      inf_d  = 1'b0;
      sent_d = 1'b0;
      occ_d  = '0;
      if (inf_q && sent_q) begin
        pop   = 1'b1;
        eof_d = 1'b1;
        st_d  = ab_st;
      end
    end else if (byte_done && inf_q) begin
      if (occ_q == lim) begin
        pop    = 1'b1;
        sof_d  = !sent_q;
        sent_d = 1'b1;
      end else begin
        occ_d = occ_q + 1'b1;
      end
    end
    if (pop) begin
      ov_d = 1'b1;
      od_d = q_q[0];
      for (int i = 0; i < HOLD_DEPTH - 1; i++) q_d[i] = q_q[i+1];
    end
    if (byte_done && inf_q && !fl_q) begin
      for (int i = 0; i < HOLD_DEPTH; i++)
        if (OCC_W'(i) == idx) q_d[i] = new_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      pre_q   <= 3'd0;
      ph_q    <= '0;
      inf_q   <= 1'b0;
      sent_q  <= 1'b0;
      fl_q    <= 1'b0;
      occ_q   <= '0;
      hold_q  <= '0;
      o_valid <= 1'b0;
      o_data  <= '0;
      o_sof   <= 1'b0;
      o_eof   <= 1'b0;
      o_stat  <= '0;
      for (int i = 0; i < HOLD_DEPTH; i++) q_q[i] <= '0;
    end else begin
      sr_q    <= sr_d;
      pre_q   <= pre_d;
      ph_q    <= ph_d;
      inf_q   <= inf_d;
      sent_q  <= sent_d;
      fl_q    <= fl_d;
      occ_q   <= occ_d;
      hold_q  <= hold_d;
      o_valid <= ov_d;
      o_data  <= od_d;
      o_sof   <= sof_d;
      o_eof   <= eof_d;
      o_stat  <= st_d;
      for (int i = 0; i < HOLD_DEPTH; i++) q_q[i] <= q_d[i];
    end
  end

  // R11
  stat_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_eof |-> ($countones({o_stat.ok, o_stat.bad, o_stat.abort}) == 1));
  // R11
  stat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !o_eof |-> (o_stat == '0));
  // R10
  misalign_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_stat.misalign |-> o_stat.bad);
  // R6
  hold_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= lim);
  // R7
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_q |-> !(byte_done || flag_ev || abort_ev));
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             cfg_crc32,
  input  logic             cfg_keep_fcs,
  output logic             out_valid,
  output logic [OCTET-1:0] out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             st_fcs_ok,
  output logic             st_fcs_bad,
  output logic             st_abort,
  output logic             st_misalign
);
  logic [1:0] rs_q;
  logic       srst_n;
  logic       dbit_vld, dbit, flag_ev, abort_ev;
  logic       crc_clr, crc_en, crc_din, good16, good32;
  rx_stat_t   stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  hdlc_rx_bitproc u_bits (
    .clk(clk), .rst_n(srst_n), .bit_en(bit_en), .bit_in(bit_in),
    .dbit_vld(dbit_vld), .dbit(dbit), .flag_ev(flag_ev), .abort_ev(abort_ev)
  );

  hdlc_rx_crc #(.W(16), .POLY(POLY16), .GOOD(GOOD16)) u_crc16 (
    .clk(clk), .rst_n(srst_n), .clr(crc_clr), .en(crc_en), .din(crc_din),
    .good(good16)
  );

  hdlc_rx_crc #(.W(32), .POLY(POLY32), .GOOD(GOOD32)) u_crc32 (
    .clk(clk), .rst_n(srst_n), .clr(crc_clr), .en(crc_en), .din(crc_din),
    .good(good32)
  );

  hdlc_rx_framer u_frm (
    .clk(clk), .rst_n(srst_n), .cfg_crc32(cfg_crc32),
    .cfg_keep_fcs(cfg_keep_fcs), .dbit_vld(dbit_vld), .dbit(dbit),
    .flag_ev(flag_ev), .abort_ev(abort_ev),
    .crc_good(cfg_crc32 ? good32 : good16),
    .crc_clr(crc_clr), .crc_en(crc_en), .crc_din(crc_din),
    .o_valid(out_valid), .o_data(out_data), .o_sof(out_sof),
    .o_eof(out_eof), .o_stat(stat)
  );

  assign st_fcs_ok   = stat.ok;
  assign st_fcs_bad  = stat.bad;
  assign st_abort    = stat.abort;
  assign st_misalign = stat.misalign;

  // R11
  sof_needs_valid_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (out_sof || out_eof) |-> out_valid);
endmodule

// File: tb/tb_hdlc_rx_deframer.sv
module tb_hdlc_rx_deframer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, bit_en, bit_in, cfg_crc32, cfg_keep_fcs;
  logic out_valid, out_sof, out_eof;
  logic st_fcs_ok, st_fcs_bad, st_abort, st_misalign;
  logic [7:0] out_data;

  int n_chk = 0, n_fail = 0, tx_ones = 0, cap_n = 0;
  bit done = 0;
  logic [7:0] pl   [0:15];
  logic [7:0] fbuf [0:23];
  logic [7:0] cap_d  [0:63];
  logic       cap_s  [0:63];
  logic       cap_e  [0:63];
  logic [3:0] cap_st [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_deframer dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .cfg_crc32(cfg_crc32), .cfg_keep_fcs(cfg_keep_fcs),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .st_fcs_ok(st_fcs_ok), .st_fcs_bad(st_fcs_bad),
    .st_abort(st_abort), .st_misalign(st_misalign)
  );

  always @(negedge clk) begin
    if (out_valid && cap_n < 64) begin
      cap_d[cap_n]  = out_data;
      cap_s[cap_n]  = out_sof;
      cap_e[cap_n]  = out_eof;
      cap_st[cap_n] = {st_fcs_ok, st_fcs_bad, st_abort, st_misalign};
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    bit_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    int gap;
    gap = $urandom_range(0, 2);
    bit_in = b;
    bit_en = 1'b1;
    @(negedge clk);
    if (gap > 0) begin
      bit_en = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic send_dbit(input logic b);
    pulse(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin
        pulse(1'b0);
        tx_ones = 0;
      end
    end else tx_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_dbit(v[i]);
  endtask

  task automatic send_flag();
    logic [7:0] f;
    f = 8'h7E;
    for (int i = 0; i < 8; i++) pulse(f[i]);
    tx_ones = 0;
  endtask

  function automatic logic [31:0] calc_crc(input int n, input bit c32);
    logic [31:0] c, poly;
    c    = c32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    poly = c32 ? 32'hEDB8_8320 : 32'h0000_8408;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++)
        c = (c >> 1) ^ ((c[0] ^ fbuf[i][j]) ? poly : 32'h0);
    return c;
  endfunction

  task automatic compare(input int exp_n, input logic [3:0] exp_st,
                         input string cnt_tag, input string st_tag);
    chk(cap_n == exp_n, cnt_tag, "beat count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(cap_d[i] == fbuf[i], "R3", "data byte", cap_d[i], fbuf[i]);
      chk(cap_s[i] == (i == 0), "R11", "sof marker", cap_s[i], (i == 0));
      chk(cap_e[i] == (i == exp_n - 1), "R11", "eof marker", cap_e[i], (i == exp_n - 1));
      if (i == exp_n - 1) chk(cap_st[i] == exp_st, st_tag, "status", cap_st[i], exp_st);
      else                chk(cap_st[i] == 4'h0, "R11", "status off eof", cap_st[i], 0);
    end
    cap_n = 0;
  endtask

  task automatic run_frame(input bit c32, input bit keep, input int plen,
                           input bit corrupt, input int extra, input int abort_k,
                           input string st_tag);
    int fcsb, lim, n, exp_n, ix;
    logic [31:0] c;
    logic [3:0] est;
    string ctag;
    fcsb = c32 ? 4 : 2;
    lim  = fcsb + 1;
    cfg_crc32    = c32;
    cfg_keep_fcs = keep;
    idle(2);
    send_flag();
    if (abort_k >= 0) begin
      for (int i = 0; i < abort_k; i++) begin
        fbuf[i] = pl[i];
        send_byte(pl[i]);
      end
      pulse(1'b0);
      repeat (8) pulse(1'b1);
      tx_ones = 0;
      idle(12);
      exp_n = (abort_k >= lim + 1) ? abort_k - lim + 1 : 0;
      compare(exp_n, 4'b0010, "R8", "R8");
    end else begin
      for (int i = 0; i < plen; i++) fbuf[i] = pl[i];
      c = ~calc_crc(plen, c32);
      for (int i = 0; i < fcsb; i++) fbuf[plen+i] = c[8*i +: 8];
      n = plen + fcsb;
      if (corrupt) begin
        ix = $urandom_range(0, n - 1);
        fbuf[ix] = fbuf[ix] ^ (8'h01 << $urandom_range(0, 7));
      end
      for (int i = 0; i < n; i++) send_byte(fbuf[i]);
      for (int i = 0; i < extra; i++) send_dbit(1'($urandom_range(0, 1)));
      send_flag();
      send_flag();
      idle(14);
      exp_n = (n < fcsb + 2) ? 0 : (keep ? n : n - fcsb);
      ctag  = (n < fcsb + 2) ? "R9" : (keep ? "R7" : "R6");
      est[0] = (extra != 0);
      est[3] = !corrupt && (extra == 0);
      est[2] = !est[3];
      est[1] = 1'b0;
      compare(exp_n, est, ctag, st_tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0;
    cfg_crc32 = 1'b0; cfg_keep_fcs = 1'b0;
    repeat (4) @(negedge clk);
    // R12: outputs quiet in reset
    chk(!out_valid && !out_sof && !out_eof, "R12", "markers in reset",
        {out_valid, out_sof, out_eof}, 0);
    chk({st_fcs_ok, st_fcs_bad, st_abort, st_misalign} == 4'h0, "R12",
        "status in reset", {st_fcs_ok, st_fcs_bad, st_abort, st_misalign}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!out_valid && !out_eof, "R12", "markers after reset", {out_valid, out_eof}, 0);
    cap_n = 0;

    // R1: bits before any flag are ignored
    for (int i = 0; i < 48; i++) pulse((i % 4 == 3) ? 1'b0 : 1'($urandom_range(0, 1)));
    idle(10);
    chk(cap_n == 0, "R1", "output before first flag", cap_n, 0);

    // R2: payload full of ones, needs destuffing; 16-bit strip
    pl[0] = 8'hFF; pl[1] = 8'h7E; pl[2] = 8'hF8; pl[3] = 8'h1F; pl[4] = 8'h3E;
    run_frame(1'b0, 1'b0, 5, 1'b0, 0, -1, "R4");
    chk(1'b1, "R2", "destuffed frame compared above", 0, 0);
    // R5 and R7: 32-bit check with forwarding
    run_frame(1'b1, 1'b1, 5, 1'b0, 0, -1, "R5");
    // R4 / R5: corrupted frames
    pl[0] = 8'h12; pl[1] = 8'h34; pl[2] = 8'h56;
    run_frame(1'b0, 1'b0, 3, 1'b1, 0, -1, "R4");
    run_frame(1'b1, 1'b0, 3, 1'b1, 0, -1, "R5");
    // R6: minimum frame with two payload bytes
    run_frame(1'b0, 1'b0, 2, 1'b0, 0, -1, "R4");
    // R9: one payload byte is too short in both widths
    run_frame(1'b0, 1'b0, 1, 1'b0, 0, -1, "R4");
    run_frame(1'b1, 1'b1, 1, 1'b0, 0, -1, "R5");
    // R9: adjacent flags
    send_flag(); send_flag(); send_flag();
    idle(10);
    chk(cap_n == 0, "R9", "adjacent flags", cap_n, 0);
    // R8: aborts early and late
    for (int i = 0; i < 16; i++) pl[i] = 8'(i * 37 + 5);
    run_frame(1'b0, 1'b0, 0, 1'b0, 0, 1, "R8");
    run_frame(1'b0, 1'b0, 0, 1'b0, 0, 8, "R8");
    run_frame(1'b1, 1'b1, 0, 1'b0, 0, 9, "R8");
    // R1: data after abort and before a flag is ignored
    repeat (20) pulse(1'b1);
    idle(6);
    chk(cap_n == 0, "R1", "ones after abort", cap_n, 0);
    // R10: misaligned lengths
    run_frame(1'b0, 1'b0, 4, 1'b0, 3, -1, "R10");
    run_frame(1'b1, 1'b1, 4, 1'b0, 7, -1, "R10");

    // random frames
    for (int f = 0; f < 48; f++) begin
      bit c32, keep, corr;
      int plen, extra, ab;
      c32  = 1'($urandom_range(0, 1));
      keep = 1'($urandom_range(0, 1));
      plen = $urandom_range(0, 12);
      corr = ($urandom_range(0, 4) == 0);
      extra = ($urandom_range(0, 5) == 0) ? $urandom_range(1, 7) : 0;
      ab    = ($urandom_range(0, 7) == 0) ? $urandom_range(0, plen) : -1;
      for (int i = 0; i < 16; i++) pl[i] = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 3) == 0) pl[0] = 8'hFF;
      run_frame(c32, keep, plen, corr, extra, ab,
                extra != 0 ? "R10" : (c32 ? "R5" : "R4"));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule